// File: doc/BRIEF.md
# Cascaded Fall-Through Queue

This block is a deep queue built by placing several identical first-word-fall-through stages in a row, all clocked by one free-running clock. Each stage's output data connects to the next stage's input. Two neighbouring stages hand a word from one to the other whenever the upstream stage holds a valid head word and the downstream stage has room. No logic outside the stages is needed for this. Words therefore travel toward the tail on their own, and free slots travel toward the head.

Writers see only the first stage. They present a word and a write enable, and they watch an active-low input-ready flag. Readers see only the last stage. The head word is always shown on the read data port while the active-low output-ready flag is low. Raising the read enable consumes that word. Stage count and per-stage depth are parameters. The total capacity is their product.

Top module: `fwft_chain`

## Requirements
- R1: After reset, `out_rdy_no` is 1 (nothing valid) and `in_rdy_no` is 0 (space available).
- R2: In fall-through mode the oldest stored word is driven on `rd_data_o` with no read request. While `out_rdy_no` is 0 and `rd_en_i` is 0, both `out_rdy_no` and `rd_data_o` hold their values into the next cycle.
- R3: A word accepted into an empty chain on clock edge k first shows `out_rdy_no` = 0 after edge k + NUM_STAGES − 1, so the latency grows by one cycle per stage.
- R4: With no reads, the chain accepts exactly NUM_STAGES × STAGE_DEPTH words before `in_rdy_no` goes to 1 and stays there.
- R5: Every accepted word is read out exactly once, in write order, under any pattern of write and read enables.
- R6: A write while `in_rdy_no` is 1 is ignored. No extra word ever appears at the read port.
- R7: A read while `out_rdy_no` is 1 is ignored and does not disturb later traffic.
- R8: When a word is read from a full chain on edge k, `in_rdy_no` first returns to 0 after edge k + NUM_STAGES − 1.
- R9: Once at least NUM_STAGES words are stored and have settled, a read and a write on every cycle keep `out_rdy_no` and `in_rdy_no` at 0 on every cycle, so throughput is one word per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; it also drives every stage-to-stage transfer |
| rst_ni | input | 1 | Asynchronous reset, active low; empties all stages |
| wr_data_i | input | DATA_W | Word to enqueue |
| wr_en_i | input | 1 | Write enable; takes effect only while `in_rdy_no` is 0 |
| in_rdy_no | output | 1 | Active-low input ready of the first stage |
| rd_data_o | output | DATA_W | Head word of the last stage |
| rd_en_i | input | 1 | Read enable; takes effect only while `out_rdy_no` is 0 |
| out_rdy_no | output | 1 | Active-low output ready of the last stage |

## Verification
A single word written into an empty chain measures the ripple latency at the tail. A read from a completely full chain measures how long the freed slot takes to reach the head. A fill with no reads, continued past full, shows the exact capacity and shows that the extra writes are dropped. A primed stream with a read and a write on every cycle separates a chain that keeps full throughput from one that inserts bubbles. Random enable phases that favour writes, favour reads, or are balanced compare every read word against a queue kept in the bench. These phases reveal reordering, loss and duplication at stage boundaries.

// File: rtl/fwft_chain_pkg.sv
package fwft_chain_pkg;
  // Advance a ring index, wrapping at depth (depth need not be a power of two).
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/fwft_stage_mem.sv
module fwft_stage_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fwft_stage.sv
module fwft_stage #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_we_i,
  output logic              in_rdy_no,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_re_i,
  output logic              out_rdy_no
);
  import fwft_chain_pkg::*;

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, push, pop;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign push  = in_we_i & ~full;
  assign pop   = out_re_i & ~empty;

  // Flags come straight from the count register: no combinational path between stages.
  assign in_rdy_no  = full;
  assign out_rdy_no = empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= PTR_W'(wrap_inc(32'(wr_ptr_q), DEPTH));
      if (pop)  rd_ptr_q <= PTR_W'(wrap_inc(32'(rd_ptr_q), DEPTH));
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  fwft_stage_mem #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) mem_i (
    .clk_i  (clk_i),
    .we_i   (push),
    .waddr_i(wr_ptr_q),
    .wdata_i(in_data_i),
    .raddr_i(rd_ptr_q),
    .rdata_o(out_data_o)
  );
endmodule

// File: rtl/fwft_chain.sv
module fwft_chain #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned STAGE_DEPTH = 4,
  parameter int unsigned NUM_STAGES  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_en_i,
  output logic              in_rdy_no,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              rd_en_i,
  output logic              out_rdy_no
);
  logic [DATA_W-1:0] stage_din  [NUM_STAGES];
  logic [DATA_W-1:0] stage_dout [NUM_STAGES];
  logic              stage_we   [NUM_STAGES];
  logic              stage_re   [NUM_STAGES];
  logic              stage_or_n [NUM_STAGES];
  logic              stage_ir_n [NUM_STAGES];

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stage_din[g] = wr_data_i;
      assign stage_we[g]  = wr_en_i;
    end else begin : g_link_in
      assign stage_din[g] = stage_dout[g-1];
      assign stage_we[g]  = ~stage_or_n[g-1] & ~stage_ir_n[g];
    end

    if (g == NUM_STAGES - 1) begin : g_tail
      assign stage_re[g] = rd_en_i;
    end else begin : g_link_out
      // Same handshake term as the downstream write: pop and push on one edge.
      assign stage_re[g] = ~stage_or_n[g] & ~stage_ir_n[g+1];
    end

    fwft_stage #(
      .DATA_W(DATA_W),
      .DEPTH (STAGE_DEPTH)
    ) stage_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_data_i (stage_din[g]),
      .in_we_i   (stage_we[g]),
      .in_rdy_no (stage_ir_n[g]),
      .out_data_o(stage_dout[g]),
      .out_re_i  (stage_re[g]),
      .out_rdy_no(stage_or_n[g])
    );
  end

  assign in_rdy_no  = stage_ir_n[0];
  assign rd_data_o  = stage_dout[NUM_STAGES-1];
  assign out_rdy_no = stage_or_n[NUM_STAGES-1];
endmodule

// File: rtl/fwft_chain_chk.sv
module fwft_chain_chk #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned STAGE_DEPTH = 4,
  parameter int unsigned NUM_STAGES  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              in_rdy_no,
  input logic              rd_en_i,
  input logic              out_rdy_no,
  input logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned CAP   = NUM_STAGES * STAGE_DEPTH;
  localparam int unsigned OCC_W = $clog2(CAP + 1) + 1;

  logic [OCC_W-1:0] occ_q;
  logic             acc_wr, acc_rd;

  assign acc_wr = wr_en_i & ~in_rdy_no;
  assign acc_rd = rd_en_i & ~out_rdy_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_q + OCC_W'(acc_wr) - OCC_W'(acc_rd);
  end

  a_r1_empty_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == '0) |-> (out_rdy_no && !in_rdy_no));

  a_r2_head_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_rdy_no && !rd_en_i) |=> (!out_rdy_no && $stable(rd_data_o)));

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= OCC_W'(CAP));

  a_r6_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == OCC_W'(CAP)) |-> in_rdy_no);
endmodule

bind fwft_chain fwft_chain_chk #(
  .DATA_W     (DATA_W),
  .STAGE_DEPTH(STAGE_DEPTH),
  .NUM_STAGES (NUM_STAGES)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .in_rdy_no (in_rdy_no),
  .rd_en_i   (rd_en_i),
  .out_rdy_no(out_rdy_no),
  .rd_data_o (rd_data_o)
);

// File: tb/fwft_chain_tb_top.sv
module fwft_chain_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW  = 8;
  localparam int unsigned SD  = 4;
  localparam int unsigned NS  = 3;
  localparam int unsigned CAP = SD * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic          in_rdy_n;
  logic          out_rdy_n;
  logic [DW-1:0] rd_data;

  int n_checks = 0;
  int n_fails  = 0;
  int n_reads  = 0;
  logic [DW-1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fwft_chain #(.DATA_W(DW), .STAGE_DEPTH(SD), .NUM_STAGES(NS)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_data_i (wr_data),
    .wr_en_i   (wr_en),
    .in_rdy_no (in_rdy_n),
    .rd_data_o (rd_data),
    .rd_en_i   (rd_en),
    .out_rdy_no(out_rdy_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  // One cycle: at the falling edge observe outputs, drive inputs, update model.
  task automatic cyc(input logic we, input logic [DW-1:0] d, input logic re);
    @(negedge clk);
    wr_en   = we;
    wr_data = d;
    rd_en   = re;
    if (re && !out_rdy_n) begin
      n_reads++;
      if (exp_q.size() == 0) check("R6 spurious word", 1, 0);
      else check("R5 order", int'(rd_data), int'(exp_q.pop_front()));
    end
    if (we && !in_rdy_n) exp_q.push_back(d);
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) cyc(1'b0, '0, 1'b1);
    for (int i = 0; i < NS + 2; i++) cyc(1'b0, '0, 1'b0);
    check("R5 all words out", exp_q.size(), 0);
    check("R5 empty after drain", int'(out_rdy_n), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int lat;
    int acc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_rdy_no in reset", int'(out_rdy_n), 1);
    check("R1 in_rdy_no in reset", int'(in_rdy_n), 0);
    rst_n = 1'b1;
    cyc(1'b0, '0, 1'b0);
    check("R1 out_rdy_no after reset", int'(out_rdy_n), 1);
    check("R1 in_rdy_no after reset", int'(in_rdy_n), 0);

    // R3 ripple latency and R2 fall-through data
    cyc(1'b1, 8'h3c, 1'b0);
    lat = -1;
    for (int j = 1; j <= 20; j++) begin
      cyc(1'b0, '0, 1'b0);
      if (!out_rdy_n) begin lat = j - 1; break; end
    end
    check("R3 edges from write to out ready", lat, NS - 1);
    check("R2 head word without read", int'(rd_data), 'h3c);
    cyc(1'b0, '0, 1'b0);
    check("R2 head held", int'(rd_data), 'h3c);
    cyc(1'b0, '0, 1'b1);
    cyc(1'b0, '0, 1'b0);
    check("R2 word consumed", int'(out_rdy_n), 1);

    // R7 reads on empty chain are ignored
    for (int i = 0; i < 5; i++) cyc(1'b0, '0, 1'b1);
    cyc(1'b1, 8'ha5, 1'b0);
    for (int i = 0; i < NS + 1; i++) cyc(1'b0, '0, 1'b0);
    check("R7 word after empty reads", int'(rd_data), 'ha5);
    check("R7 out ready after empty reads", int'(out_rdy_n), 0);
    drain();

    // R4 capacity, R6 writes when full ignored
    acc = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, DW'(i + 16), 1'b0);
      if (!in_rdy_n) acc++;
    end
    for (int i = 0; i < 10; i++) cyc(1'b0, '0, 1'b0);
    check("R4 accepted words", acc, CAP);
    check("R4 in_rdy_no stays high", int'(in_rdy_n), 1);

    // R8 free slot bubbles back to the head
    cyc(1'b0, '0, 1'b1);
    lat = -1;
    for (int j = 1; j <= 20; j++) begin
      cyc(1'b0, '0, 1'b0);
      if (!in_rdy_n) begin lat = j - 1; break; end
    end
    check("R8 edges from read to in ready", lat, NS - 1);
    n_reads = 1;
    drain();
    check("R6 words read after overfill", n_reads, CAP);

    // R9 streaming at one word per cycle
    for (int i = 0; i < 2 * NS; i++) cyc(1'b1, DW'(i + 100), 1'b0);
    for (int i = 0; i < 10; i++) cyc(1'b0, '0, 1'b0);
    acc = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, DW'(i + 200), 1'b1);
      if (i > 0 && (out_rdy_n || in_rdy_n)) acc++;
    end
    check("R9 bubbles while streaming", acc, 0);
    drain();

    // R5 random traffic: write-heavy, read-heavy, balanced
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 1000; i++) begin
        int r;
        logic we, re;
        r  = int'($urandom_range(0, 99));
        we = (r < (ph == 0 ? 80 : ph == 1 ? 30 : 50));
        r  = int'($urandom_range(0, 99));
        re = (r < (ph == 0 ? 30 : ph == 1 ? 80 : 50));
        cyc(we, DW'($urandom), re);
      end
    end
    drain();
    summary();
  end
endmodule